// File: doc/BRIEF.md
# Errors-and-Erasures Key Equation Solver, Division-Free

This block sits between syndrome/erasure preprocessing and the root search of a (7,3) Reed-Solomon decoder over GF(8). It receives the erasure locator polynomial, the shifted modified syndromes and the erasure count. It then runs a division-free Berlekamp-Massey recursion at one iteration per clock and returns a polynomial whose roots mark every errored and every erased symbol.

The solver starts from the erasure locator rather than from the constant 1. It spends one iteration on each syndrome degree of freedom that the erasures leave free, so the run length is 2t minus the erasure count. The result is a nonzero scalar multiple of the true locator. No field inversion is needed anywhere, because the roots of a polynomial do not change when it is scaled.

Field elements are 3-bit vectors in polynomial basis, with alpha = x and the field built on x^3+x+1. Polynomial coefficient i occupies bits [3i+2:3i] of its port. Symbol position j has locator alpha^j. The syndromes are S_i = R(alpha^(i+1)) for i = 0..3. Input coefficient i of `fsyn_i` must equal coefficient i+rho of Gamma(z)·S(z), where Gamma is the erasure locator and S(z) = sum S_i z^i. Coefficients beyond 3-rho are zero.

Top module: `ks_eras_keysolver`

## Requirements
- R1: After reset, busy_o, done_o and reject_o are 0 and lambda_o is all zeros.
- R2: A start seen while idle with rho ≤ 4 raises busy_o on the next cycle. The block then performs exactly 4-rho iterations. done_o pulses for exactly one cycle, 4-rho+1 clock edges after the start edge, and busy_o is low from that cycle on.
- R3: A start seen while idle with rho > 4 gives a one-cycle reject_o on the next cycle. In that case busy_o stays low, done_o stays low and lambda_o is unchanged.
- R4: With no erasures and e ≤ 2 symbol errors, lambda_o equals c·prod(1 + alpha^j z) over the error positions j, for some nonzero c.
- R5: With erasures only (no errors, rho ≤ 4), lambda_o equals the erasure locator exactly.
- R6: With rho erasures and e errors where 2e+rho ≤ 4, lambda_o equals c·Gamma(z)·prod(1 + alpha^j z) over the error positions, for some nonzero c.
- R7: With rho = 4 the block performs no iteration. done_o pulses one edge after the start edge, and lambda_o equals the erasure locator.
- R8: A start asserted while busy_o is high is ignored. The run in progress ends at its own time with its own result.
- R9: While idle and without an accepted start, lambda_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to load inputs and begin solving |
| rho_i | input | 3 | Number of erasures |
| eras_loc_i | input | 15 | Erasure locator, 5 coefficients of 3 bits, degree 0 lowest |
| fsyn_i | input | 12 | Shifted modified syndromes, 4 coefficients of 3 bits |
| lambda_o | output | 15 | Combined error-and-erasure locator, 5 coefficients |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse: lambda_o is final |
| reject_o | output | 1 | One-cycle pulse: start refused because rho exceeds 2t |

## Verification
The bench builds received words from chosen error and erasure patterns and computes syndromes and locators in its own field arithmetic. It accepts any nonzero scaling of the expected polynomial. Mixed cases exercise the coupling between the shortened run length and the erasure-seeded start: a design that iterates 2t times, or seeds with 1, returns a polynomial missing the erasure roots or carrying spurious ones.

The edge cases are these. rho = 4 must finish with zero iterations, and a counter that underflows would hang or overrun. An over-limit rho must be refused rather than run with a wrapped count. A start arriving mid-run must not reload the registers, or the result would be corrupted. An error-free word must leave the discrepancy at zero throughout, so the unscaled seed comes back unchanged.

// File: rtl/ks_pkg.sv
// Shared types for the errors-and-erasures key solver.
package ks_pkg;
    typedef enum logic {KS_IDLE = 1'b0, KS_RUN = 1'b1} ks_state_e;
endpackage

// File: rtl/ks_gf_mul.sv
// Combinational GF(2^M) multiplier, polynomial basis.
// Assumes PRIM is a primitive polynomial of degree M (bit M set).
module ks_gf_mul #(
    parameter int         M    = 3,
    parameter logic [M:0] PRIM = 4'b1011
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] p
);
    // Shift-and-add product with reduction on every shift.
    always_comb begin
        logic [M-1:0] acc;
        logic [M-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[M-1]) sh = (sh << 1) ^ PRIM[M-1:0];
            else         sh = sh << 1;
        end
        p = acc;
    end
endmodule

// File: rtl/ks_loc_pe.sv
// One coefficient slice of the locator and its auxiliary polynomial.
// Assumes b_prev carries coefficient IDX-1 of the auxiliary (zero for IDX 0),
// so that the slice sees z*B.
module ks_loc_pe #(
    parameter int         M    = 3,
    parameter logic [M:0] PRIM = 4'b1011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         flag,
    input  logic [M-1:0] gamma,
    input  logic [M-1:0] d0,
    input  logic [M-1:0] init,
    input  logic [M-1:0] b_prev,
    output logic [M-1:0] lam_q,
    output logic [M-1:0] b_q
);
    logic [M-1:0] g_lam;
    logic [M-1:0] d_b;

    ks_gf_mul #(.M(M), .PRIM(PRIM)) u_mul_g (.a(gamma), .b(lam_q),  .p(g_lam));
    ks_gf_mul #(.M(M), .PRIM(PRIM)) u_mul_d (.a(d0),    .b(b_prev), .p(d_b));

    // Seed from the erasure locator, then apply one update per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lam_q <= '0;
            b_q   <= '0;
        end else if (load) begin
            lam_q <= init;
            b_q   <= init;
        end else if (step) begin
            lam_q <= g_lam ^ d_b;
            b_q   <= flag ? lam_q : b_prev;
        end
    end

    // Without a swap the auxiliary shifts up by one position.
    assert_b_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !flag) |=> (b_q == $past(b_prev)));
endmodule

// File: rtl/ks_disc_pe.sv
// One slice of the discrepancy vector and its stored companion.
// Assumes d_next is the next-higher discrepancy coefficient (zero at the top).
module ks_disc_pe #(
    parameter int         M    = 3,
    parameter logic [M:0] PRIM = 4'b1011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         flag,
    input  logic [M-1:0] gamma,
    input  logic [M-1:0] d0,
    input  logic [M-1:0] init,
    input  logic [M-1:0] d_next,
    output logic [M-1:0] del_q,
    output logic [M-1:0] th_q
);
    logic [M-1:0] g_d;
    logic [M-1:0] d_th;

    ks_gf_mul #(.M(M), .PRIM(PRIM)) u_mul_g (.a(gamma), .b(d_next), .p(g_d));
    ks_gf_mul #(.M(M), .PRIM(PRIM)) u_mul_d (.a(d0),    .b(th_q),   .p(d_th));

    // Seed from the modified syndromes, then advance one degree per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            del_q <= '0;
            th_q  <= '0;
        end else if (load) begin
            del_q <= init;
            th_q  <= init;
        end else if (step) begin
            del_q <= g_d ^ d_th;
            th_q  <= flag ? d_next : th_q;
        end
    end

    // The companion vector is frozen on non-swap steps.
    assert_theta_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !flag) |=> $stable(th_q));
endmodule

// File: rtl/ks_ctrl.sv
// Sequencer: accepts start, counts 2t-rho iterations, keeps gamma and k,
// and raises the swap flag. Assumes d0 is the lowest discrepancy register.
module ks_ctrl
    import ks_pkg::*;
#(
    parameter int M     = 3,
    parameter int T     = 2,
    parameter int RHO_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RHO_W-1:0] rho,
    input  logic [M-1:0]     d0,
    output logic             load,
    output logic             step,
    output logic             flag,
    output logic [M-1:0]     gamma,
    output logic             busy,
    output logic             done,
    output logic             reject
);
    localparam int TWO_T = 2 * T;
    localparam int RW    = $clog2(TWO_T + 1);
    localparam int KW    = $clog2(TWO_T + 1) + 1;

    ks_state_e             state_q;
    logic [RW-1:0]         rem_q;
    logic signed [KW-1:0]  k_q;
    logic                  rho_bad;

    assign rho_bad = ({1'b0, rho} > (RHO_W + 1)'(TWO_T));
    assign busy    = (state_q == KS_RUN);
    assign load    = !busy && start && !rho_bad;
    assign step    = busy && (rem_q != '0);
    assign flag    = (d0 != '0) && !k_q[KW-1];

    // Run state, iteration counter, pulses, gamma and k.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            rem_q   <= '0;
            k_q     <= '0;
            gamma   <= '0;
            done    <= 1'b0;
            reject  <= 1'b0;
        end else begin
            done   <= 1'b0;
            reject <= 1'b0;
            if (!busy) begin
                if (start && rho_bad) begin
                    reject <= 1'b1;
                end else if (load) begin
                    state_q <= KS_RUN;
                    rem_q   <= RW'(TWO_T) - RW'(rho);
                    k_q     <= '0;
                    gamma   <= M'(1);
                end
            end else if (step) begin
                rem_q <= rem_q - RW'(1);
                if (flag) begin
                    gamma <= d0;
                    k_q   <= ~k_q;
                end else begin
                    k_q   <= k_q + KW'(1);
                end
            end else begin
                state_q <= KS_IDLE;
                done    <= 1'b1;
            end
        end
    end

    assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rho_bad) |=> (reject && !busy && !done));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    assert_keep_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> busy);
    assert_k_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((k_q >= -TWO_T) && (k_q <= TWO_T)));
endmodule

// File: rtl/ks_eras_keysolver.sv
// Division-free errors-and-erasures key equation solver, one iteration per
// clock. Assumes fsyn_i holds coefficients rho..2t-1 of Gamma(z)S(z),
// zero-padded, and eras_loc_i holds Gamma(z) with Gamma_0 = 1.
module ks_eras_keysolver #(
    parameter int         M     = 3,
    parameter int         T     = 2,
    parameter logic [M:0] PRIM  = 4'b1011,
    parameter int         RHO_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [RHO_W-1:0]       rho_i,
    input  logic [(2*T+1)*M-1:0]   eras_loc_i,
    input  logic [2*T*M-1:0]       fsyn_i,
    output logic [(2*T+1)*M-1:0]   lambda_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   reject_o
);
    localparam int NS = 2 * T;
    localparam int NL = 2 * T + 1;

    logic         load;
    logic         step;
    logic         flag;
    logic [M-1:0] gamma;
    logic [M-1:0] lam_w [NL];
    logic [M-1:0] b_w   [NL];
    logic [M-1:0] del_w [NS];
    logic [M-1:0] th_w  [NS];

    ks_ctrl #(.M(M), .T(T), .RHO_W(RHO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rho(rho_i), .d0(del_w[0]),
        .load(load), .step(step), .flag(flag), .gamma(gamma),
        .busy(busy_o), .done(done_o), .reject(reject_o)
    );

    for (genvar i = 0; i < NL; i++) begin : g_loc
        logic [M-1:0] bp;
        if (i == 0) begin : g_first
            assign bp = '0;
        end else begin : g_rest
            assign bp = b_w[i-1];
        end
        ks_loc_pe #(.M(M), .PRIM(PRIM)) u_pe (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step), .flag(flag),
            .gamma(gamma), .d0(del_w[0]), .init(eras_loc_i[i*M +: M]),
            .b_prev(bp), .lam_q(lam_w[i]), .b_q(b_w[i])
        );
        assign lambda_o[i*M +: M] = lam_w[i];
    end

    for (genvar i = 0; i < NS; i++) begin : g_disc
        logic [M-1:0] dn;
        if (i == NS - 1) begin : g_top
            assign dn = '0;
        end else begin : g_mid
            assign dn = del_w[i+1];
        end
        ks_disc_pe #(.M(M), .PRIM(PRIM)) u_pe (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step), .flag(flag),
            .gamma(gamma), .d0(del_w[0]), .init(fsyn_i[i*M +: M]),
            .d_next(dn), .del_q(del_w[i]), .th_q(th_w[i])
        );
    end

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start) |=> $stable(lambda_o));
    assert_load_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start && step) |=> (busy_o || done_o));
endmodule

// File: tb/tb_ks_eras_keysolver.sv
module tb_ks_eras_keysolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  rho_i = '0;
    logic [14:0] eras_loc_i = '0;
    logic [11:0] fsyn_i = '0;
    logic [14:0] lambda_o;
    logic        busy_o, done_o, reject_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ks_eras_keysolver dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rho_i(rho_i),
        .eras_loc_i(eras_loc_i), .fsyn_i(fsyn_i), .lambda_o(lambda_o),
        .busy_o(busy_o), .done_o(done_o), .reject_o(reject_o)
    );

    // Case description and derived expectations
    int n_er, n_err;
    int er_pos[4], er_val[4];
    int e_pos[2], e_val[2];
    int gam[5];
    int expl[5];

    function automatic int gm(int a, int b);
        int r = 0;
        for (int i = 0; i < 3; i++) begin
            if ((b >> i) & 1) r = r ^ a;
            a = a << 1;
            if (a & 8) a = a ^ 11;
        end
        return r;
    endfunction

    function automatic int gpow(int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = gm(r, 2);
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Build syndromes, erasure locator, shifted inputs and expected locator.
    task automatic build();
        int s[4];
        int p[8];
        int tmp[6];
        for (int i = 0; i < 4; i++) begin
            s[i] = 0;
            for (int j = 0; j < n_er; j++)  s[i] ^= gm(er_val[j], gpow((er_pos[j] * (i + 1)) % 7));
            for (int j = 0; j < n_err; j++) s[i] ^= gm(e_val[j], gpow((e_pos[j] * (i + 1)) % 7));
        end
        for (int i = 0; i < 5; i++) gam[i] = (i == 0) ? 1 : 0;
        for (int j = 0; j < n_er; j++) begin
            tmp[0] = gam[0];
            for (int i = 1; i < 5; i++) tmp[i] = gam[i] ^ gm(gpow(er_pos[j]), gam[i-1]);
            for (int i = 0; i < 5; i++) gam[i] = tmp[i];
        end
        for (int i = 0; i < 8; i++) p[i] = 0;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 4; j++) p[i+j] ^= gm(gam[i], s[j]);
        for (int i = 0; i < 5; i++) expl[i] = gam[i];
        for (int j = 0; j < n_err; j++) begin
            tmp[0] = expl[0];
            for (int i = 1; i < 5; i++) tmp[i] = expl[i] ^ gm(gpow(e_pos[j]), expl[i-1]);
            for (int i = 0; i < 5; i++) expl[i] = tmp[i];
        end
        rho_i = 3'(n_er);
        for (int i = 0; i < 5; i++) eras_loc_i[i*3 +: 3] = 3'(gam[i]);
        for (int i = 0; i < 4; i++) fsyn_i[i*3 +: 3] = (i + n_er < 4) ? 3'(p[i + n_er]) : 3'd0;
    endtask

    function automatic int lam(int i);
        return int'(lambda_o[i*3 +: 3]);
    endfunction

    // Start a run, check latency and busy, optionally poke start mid-run.
    task automatic run(string req, bit exact, bit poke);
        int lat = 0;
        int nexp = 4 - n_er;
        int c;
        @(negedge clk);
        build();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; rho_i = 3'd1; eras_loc_i = 15'h7fff; fsyn_i = 12'hfff;
            lat = 1;
            if (done_o) lat = 0;
            @(negedge clk);
            start = 1'b0;
            lat = 2;
        end
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (poke) chk(lat == nexp + 1, "R8", "latency with start while busy", lat, nexp + 1);
        else      chk(lat == nexp + 1, "R2", "done latency", lat, nexp + 1);
        chk(busy_o == 1'b0, "R2", "busy low at done", busy_o, 0);
        c = lam(0);
        if (exact) begin
            for (int i = 0; i < 5; i++)
                chk(lam(i) == gam[i], req, $sformatf("locator coef %0d equals erasure locator", i), lam(i), gam[i]);
        end else begin
            chk(c != 0, req, "nonzero scale", c, 1);
            for (int i = 0; i < 5; i++)
                chk(lam(i) == gm(c, expl[i]), req, $sformatf("locator coef %0d", i), lam(i), gm(c, expl[i]));
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R2", "done is one cycle", done_o, 0);
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && done_o == 0 && reject_o == 0, "R1", "flags after reset",
            {busy_o, done_o, reject_o}, 0);
        chk(lambda_o == '0, "R1", "locator after reset", int'(lambda_o), 0);
    endtask

    task automatic t_eras_only();
        n_err = 0;
        n_er = 2; er_pos[0] = 1; er_pos[1] = 5; er_val[0] = 3; er_val[1] = 6;
        run("R5", 1'b1, 1'b0);
        n_er = 1; er_pos[0] = 4; er_val[0] = 0;
        run("R5", 1'b1, 1'b0);
        n_er = 3; er_pos[0] = 0; er_pos[1] = 2; er_pos[2] = 6;
        er_val[0] = 1; er_val[1] = 7; er_val[2] = 2;
        run("R5", 1'b1, 1'b0);
    endtask

    task automatic t_err_only();
        n_er = 0;
        n_err = 0;
        run("R4", 1'b0, 1'b0);
        n_err = 1; e_pos[0] = 3; e_val[0] = 5;
        run("R4", 1'b0, 1'b0);
        n_err = 2; e_pos[0] = 0; e_pos[1] = 6; e_val[0] = 4; e_val[1] = 1;
        run("R4", 1'b0, 1'b0);
        n_err = 2; e_pos[0] = 2; e_pos[1] = 3; e_val[0] = 7; e_val[1] = 2;
        run("R4", 1'b0, 1'b0);
    endtask

    task automatic t_mixed();
        n_er = 2; er_pos[0] = 0; er_pos[1] = 4; er_val[0] = 6; er_val[1] = 3;
        n_err = 1; e_pos[0] = 2; e_val[0] = 5;
        run("R6", 1'b0, 1'b0);
        n_er = 1; er_pos[0] = 6; er_val[0] = 1;
        n_err = 1; e_pos[0] = 1; e_val[0] = 7;
        run("R6", 1'b0, 1'b0);
    endtask

    task automatic t_full_erasure();
        n_err = 0;
        n_er = 4; er_pos[0] = 0; er_pos[1] = 1; er_pos[2] = 3; er_pos[3] = 5;
        er_val[0] = 2; er_val[1] = 0; er_val[2] = 4; er_val[3] = 7;
        run("R7", 1'b1, 1'b0);
    endtask

    task automatic t_busy_start();
        n_er = 0; n_err = 2; e_pos[0] = 1; e_pos[1] = 4; e_val[0] = 3; e_val[1] = 6;
        run("R8", 1'b0, 1'b1);
    endtask

    task automatic t_reject_and_hold();
        logic [14:0] held;
        held = lambda_o;
        repeat (5) @(negedge clk);
        chk(lambda_o == held, "R9", "locator held while idle", int'(lambda_o), int'(held));
        for (int v = 5; v < 8; v += 2) begin
            rho_i = 3'(v); eras_loc_i = 15'h1234; fsyn_i = 12'h5a5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(reject_o == 1'b1, "R3", "reject pulse", reject_o, 1);
            chk(busy_o == 1'b0, "R3", "not busy on reject", busy_o, 0);
            @(negedge clk);
            chk(reject_o == 1'b0, "R3", "reject is one cycle", reject_o, 0);
            repeat (6) begin
                @(negedge clk);
                chk(done_o == 1'b0 && busy_o == 1'b0, "R3", "no run after reject", {busy_o, done_o}, 0);
            end
            chk(lambda_o == held, "R3", "locator unchanged on reject", int'(lambda_o), int'(held));
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_eras_only();
        t_err_only();
        t_mixed();
        t_full_erasure();
        t_busy_start();
        t_reject_and_hold();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule